// File: doc/BRIEF.md
# Serial Mode-Control Register Interface

This block is the write-only control port of a mixed-signal front end. A host drives three wires: an active-low select, a serial clock and a data line. It sends 16-bit frames. Each frame carries a 12-bit data field first and a 4-bit register address last, so the target register is known only when the final bit arrives. When the select rises after exactly 16 bits, the data is written into one of ten control registers. The decoded contents appear as parallel outputs: the operating mode, the auxiliary converter enables, the transmit full-scale select, three auxiliary DAC codes, two offset trims, a common-mode select and the wake-up mode. A write to the conversion address does not store anything. It emits a one-cycle start pulse for the auxiliary ADC.

The serial pins are oversampled in the system clock domain through two-flop synchronizers. This keeps every register and the start pulse on one clock, and the interface stays live in every power mode, including shutdown. The serial clock must run at less than a quarter of the system clock.

Operating mode codes, used by the two mode-control registers and by the wake-up register: 000 shutdown, 001 idle, 010 standby, 011 receive, 100 transmit, 101 full-duplex, 110 slow, 111 fast.

Top module: `ser_mode_ctl`

## Requirements
- R1: After reset, `op_mode` is 000 (shutdown), `wake_mode` is 001 (idle), and all enables, codes, trims, `cm_sel` and `adc_start` are zero.
- R2: While `cs_n` is low, a bit is taken from `sdi` on each rising `sclk` edge, first bit first. A 16-bit frame is read as data bits D11..D0 followed by address bits A3..A0. It is committed when `cs_n` rises.
- R3: A frame with fewer or more than 16 bits between the fall and the rise of `cs_n` is discarded, and no output changes.
- R4: The address map is as follows. 0 is the wide mode register and 8 is the short mode register. 1, 2 and 3 load the full 12-bit DAC1/DAC2/DAC3 codes. 4 and 5 load D5..D0 into the I and Q trims. 6 loads D1..D0 into `cm_sel`. 7 is the conversion start and 9 is the wake-up register. Addresses 10 to 15 change no output.
- R5: In the wide mode register, D2..D0 is the mode code, and D4, D5 and D6 enable auxiliary DAC1, DAC2 and DAC3 (`aux_dac_en` bits 0, 1 and 2). D7 drives `tx_fs_hi` and D9 drives `aux_adc_en`. D3, D8, D10 and D11 have no effect.
- R6: A wide mode write with code 101 (full-duplex) leaves `op_mode` unchanged, while its other fields are still applied.
- R7: The short mode register takes any code in D2..D0, full-duplex included. It leaves `aux_dac_en`, `tx_fs_hi` and `aux_adc_en` unchanged.
- R8: If `op_mode` is shutdown and a mode write carries a code other than 000, `op_mode` becomes `wake_mode` instead of that code. A wake-up register write with D2..D0 = 000 leaves `wake_mode` unchanged.
- R9: A committed write to address 7 raises `adc_start` for exactly one system clock cycle, whatever the data. No other address raises it.
- R10: `sclk` edges while `cs_n` is high are not counted and do not shift data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial frame select, active low |
| sclk | input | 1 | Serial bit clock |
| sdi | input | 1 | Serial data in |
| op_mode | output | 3 | Active operating mode code |
| aux_dac_en | output | 3 | Auxiliary DAC enables, bit i enables DAC i+1 |
| tx_fs_hi | output | 1 | Transmit full-scale select |
| aux_adc_en | output | 1 | Auxiliary ADC enable |
| dac1_code | output | 12 | Auxiliary DAC1 code |
| dac2_code | output | 12 | Auxiliary DAC2 code |
| dac3_code | output | 12 | Auxiliary DAC3 code |
| i_trim | output | 6 | I-channel offset trim |
| q_trim | output | 6 | Q-channel offset trim |
| cm_sel | output | 2 | Output common-mode select |
| wake_mode | output | 3 | Mode entered on leaving shutdown |
| adc_start | output | 1 | One-cycle auxiliary conversion start |

## Verification
The hardest case to reach is the redirect out of shutdown. The bench must first load a non-default wake mode through the wake-up register while the part is shut down. It then issues a mode write with a different code and sees `op_mode` land on the stored wake mode. This is done twice: once through the short register and once through the wide register after a return to shutdown. Malformed frames of 15 and 17 bits aimed at a DAC register, and `sclk` toggling with `cs_n` high, check that only a clean 16-bit frame ever commits.

// File: rtl/ser_mode_ctl.sv
module ser_mode_ctl #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 12,
  parameter int OFS_W  = 6,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic [2:0]        op_mode,
  output logic [2:0]        aux_dac_en,
  output logic              tx_fs_hi,
  output logic              aux_adc_en,
  output logic [DATA_W-1:0] dac1_code,
  output logic [DATA_W-1:0] dac2_code,
  output logic [DATA_W-1:0] dac3_code,
  output logic [OFS_W-1:0]  i_trim,
  output logic [OFS_W-1:0]  q_trim,
  output logic [1:0]        cm_sel,
  output logic [2:0]        wake_mode,
  output logic              adc_start
);
  localparam int FRAME_W = DATA_W + ADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  localparam logic [ADDR_W-1:0] A_WIDE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DAC1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DAC2 = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DAC3 = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_ITRM = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_QTRM = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_CMS  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_CONV = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_SHRT = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_WAKE = ADDR_W'(9);

  localparam logic [2:0] M_SHDN = 3'd0;
  localparam logic [2:0] M_IDLE = 3'd1;
  localparam logic [2:0] M_FD   = 3'd5;

  logic [SYNC_N:0] cs_sy, ck_sy, d_sy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sy <= '1;
      ck_sy <= '0;
      d_sy  <= '0;
    end else begin
      cs_sy <= {cs_sy[SYNC_N-1:0], cs_n};
      ck_sy <= {ck_sy[SYNC_N-1:0], sclk};
      d_sy  <= {d_sy[SYNC_N-1:0], sdi};
    end

  wire ck_rise = ck_sy[SYNC_N-1] & ~ck_sy[SYNC_N];
  wire cs_rise = cs_sy[SYNC_N-1] & ~cs_sy[SYNC_N];
  wire cs_fall = ~cs_sy[SYNC_N-1] & cs_sy[SYNC_N];
  wire cs_low  = ~cs_sy[SYNC_N-1];

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (cs_fall) begin
      cnt <= '0;
    end else if (ck_rise && cs_low) begin
      sh <= {sh[FRAME_W-2:0], d_sy[SYNC_N-1]};
      if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
    end

  wire                commit = cs_rise && (cnt == CNT_FULL);
  wire [ADDR_W-1:0]   addr   = sh[ADDR_W-1:0];
  wire [DATA_W-1:0]   dat    = sh[FRAME_W-1:ADDR_W];
  wire [2:0]          req    = dat[2:0];
  wire [2:0]          mode_nx = (op_mode == M_SHDN && req != M_SHDN) ? wake_mode : req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      op_mode    <= M_SHDN;
      aux_dac_en <= '0;
      tx_fs_hi   <= 1'b0;
      aux_adc_en <= 1'b0;
      dac1_code  <= '0;
      dac2_code  <= '0;
      dac3_code  <= '0;
      i_trim     <= '0;
      q_trim     <= '0;
      cm_sel     <= '0;
      wake_mode  <= M_IDLE;
    end else if (commit) begin
      case (addr)
        A_WIDE: begin
          aux_dac_en <= dat[6:4];
          tx_fs_hi   <= dat[7];
          aux_adc_en <= dat[9];
          if (req != M_FD) op_mode <= mode_nx;
        end
        A_SHRT: op_mode   <= mode_nx;
        A_DAC1: dac1_code <= dat;
        A_DAC2: dac2_code <= dat;
        A_DAC3: dac3_code <= dat;
        A_ITRM: i_trim    <= dat[OFS_W-1:0];
        A_QTRM: q_trim    <= dat[OFS_W-1:0];
        A_CMS:  cm_sel    <= dat[1:0];
        A_WAKE: if (req != M_SHDN) wake_mode <= req;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) adc_start <= 1'b0;
    else        adc_start <= commit && (addr == A_CONV);

  // R3
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cnt != CNT_FULL) |=> $stable({op_mode, aux_dac_en, tx_fs_hi, aux_adc_en,
      dac1_code, dac2_code, dac3_code, i_trim, q_trim, cm_sel, wake_mode}));

  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R6
  fd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr == A_WIDE && req == M_FD) |=> $stable(op_mode));

  // R8
  wake_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_mode != M_SHDN);

  // R2
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_OVER);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_low && !cs_fall) |=> $stable(sh));
endmodule

// File: tb/sim_ser_mode_ctl.sv
module sim_ser_mode_ctl;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0;
  logic [2:0] op_mode, aux_dac_en, wake_mode;
  logic tx_fs_hi, aux_adc_en, adc_start;
  logic [11:0] dac1_code, dac2_code, dac3_code;
  logic [5:0] i_trim, q_trim;
  logic [1:0] cm_sel;
  int n_run = 0, n_fail = 0, pulses = 0, hi_run = 0, max_run = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ser_mode_ctl u0 (.clk, .rst_n, .cs_n, .sclk, .sdi, .op_mode, .aux_dac_en, .tx_fs_hi,
    .aux_adc_en, .dac1_code, .dac2_code, .dac3_code, .i_trim, .q_trim, .cm_sel,
    .wake_mode, .adc_start);

  always @(negedge clk) begin
    if (adc_start) begin
      if (hi_run == 0) pulses++;
      hi_run++;
      if (hi_run > max_run) max_run = hi_run;
    end else hi_run = 0;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bits(logic [31:0] w, int n);
    cs_n = 0; #40;
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i]; #20; sclk = 1; #20; sclk = 0;
    end
    #40; cs_n = 1; #60;
  endtask

  task automatic wr(logic [3:0] a, logic [11:0] d);
    send_bits({16'h0, d, a}, 16);
  endtask

  task automatic t_reset;
    check("R1 op_mode", op_mode, 0);
    check("R1 wake_mode", wake_mode, 1);
    check("R1 enables", {aux_dac_en, tx_fs_hi, aux_adc_en}, 0);
    check("R1 codes", {dac1_code, dac2_code, dac3_code, i_trim, q_trim, cm_sel, adc_start}, 0);
  endtask

  task automatic t_regs;
    wr(1, 12'hABC); wr(2, 12'h123); wr(3, 12'hFFF);
    check("R2 dac1", dac1_code, 12'hABC);
    check("R4 dac2", dac2_code, 12'h123);
    check("R4 dac3", dac3_code, 12'hFFF);
    wr(4, 12'hFAB); wr(5, 12'h015); wr(6, 12'hFFE);
    check("R4 i_trim", i_trim, 6'h2B);
    check("R4 q_trim", q_trim, 6'h15);
    check("R4 cm_sel", cm_sel, 2);
  endtask

  task automatic t_unused;
    for (int a = 10; a < 16; a++) wr(4'(a), 12'hFFF);
    check("R4 unused", {op_mode, aux_dac_en, tx_fs_hi, aux_adc_en, dac1_code, dac2_code,
      dac3_code, i_trim, q_trim, cm_sel, wake_mode},
      {3'd0, 3'd0, 2'b0, 12'hABC, 12'h123, 12'hFFF, 6'h2B, 6'h15, 2'd2, 3'd1});
  endtask

  task automatic t_len;
    send_bits({16'h0, 12'h555, 4'd1} >> 1, 15);
    check("R3 short frame", dac1_code, 12'hABC);
    send_bits({15'h0, 12'h555, 4'd1, 1'b0}, 17);
    check("R3 long frame", dac1_code, 12'hABC);
    wr(1, 12'h555);
    check("R3 recover", dac1_code, 12'h555);
  endtask

  task automatic t_idle_clk;
    sdi = 1;
    for (int i = 0; i < 5; i++) begin #20; sclk = 1; #20; sclk = 0; end
    #40;
    wr(2, 12'h0F0);
    check("R10 idle sclk", dac2_code, 12'h0F0);
  endtask

  task automatic t_wake;
    wr(9, 12'hFF8);
    check("R8 wake zero kept", wake_mode, 1);
    wr(9, 12'h003);
    check("R8 wake load", wake_mode, 3);
    wr(8, 12'h002);
    check("R8 leave shdn", op_mode, 3);
    wr(8, 12'h005);
    check("R7 short fd", op_mode, 5);
    wr(8, 12'h000);
    wr(0, 12'h004);
    check("R8 wide leave shdn", op_mode, 3);
  endtask

  task automatic t_wide;
    wr(0, 12'hFDC);
    check("R5 mode", op_mode, 4);
    check("R5 fields", {aux_dac_en, tx_fs_hi, aux_adc_en}, {3'b101, 1'b1, 1'b1});
    wr(0, 12'h005);
    check("R6 fd hold", op_mode, 4);
    check("R6 fields", {aux_dac_en, tx_fs_hi, aux_adc_en}, 0);
    wr(0, 12'h072);
    wr(8, 12'hFF1);
    check("R7 short mode", op_mode, 1);
    check("R7 fields kept", {aux_dac_en, tx_fs_hi, aux_adc_en}, {3'b111, 2'b0});
  endtask

  task automatic t_start;
    int p0;
    p0 = pulses;
    wr(1, 12'h555); wr(9, 12'h003); wr(0, 12'h072);
    check("R9 no pulse", pulses - p0, 0);
    wr(7, 12'hABC);
    check("R9 one pulse", pulses - p0, 1);
    check("R9 width", max_run, 1);
    wr(7, 12'h000);
    check("R9 second", pulses - p0, 2);
  endtask

  initial begin
    #20 rst_n = 1; #20;
    t_reset; t_regs; t_unused; t_len; t_idle_clk; t_wake; t_wide; t_start;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin #800000; n_run++; n_fail++; $display("FAIL watchdog: actual timeout expected done"); end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule